// File: doc/BRIEF.md
# Dual Interval Timer with Interrupts

This block is a byte-wide register-mapped peripheral that holds two 16-bit down-counters. Each counter has its own reload latch. The host reaches the registers over a synchronous bus made of a 4-bit address, a write strobe and a read strobe. The counters step once for every cycle in which the `tick` enable is high, so the host's clock divider sets the time base.

The first timer runs either one-shot or free-running, as set by a mode register. The second timer always stops after one period. When a counter passes zero it reloads from its latch. If its enable bit is set, it also raises its flag. A flag register and an enable register combine the two events into one registered, active-high interrupt request.

The host starts a timer by writing the high byte of its latch. A separate address loads the first timer's latch high byte without restarting it. Reading a timer's low counter byte acknowledges that timer's flag.

Top module: `dual_timer`

## Requirements
- R1: After reset, timer 1 is running in free-run mode with counter 0x0000 and latch 0x1FFF. Timer 2 is stopped. Both flags are clear. The timer 1 enable is 0 and the timer 2 enable is 1. Reading offset 11 gives 0x40, offset 14 gives 0xA0 and offset 13 gives 0x00.
- R2: A write to offset 4 or 6 changes only the low byte of the timer 1 latch. A write to offset 8 changes only the low byte of the timer 2 latch. Neither write changes a counter.
- R3: A write to offset 5 (timer 1) or offset 9 (timer 2) does four things: it stores the latch high byte, copies the whole new latch into the counter, clears that timer's flag and sets the timer running. A tick in the same cycle does not decrement the counter.
- R4: A write to offset 7 stores the timer 1 latch high byte and clears the timer 1 flag. It leaves the timer 1 counter and its run state unchanged.
- R5: A running counter steps down by one on each tick. A tick while the counter is 0 is an underflow: the counter reloads from its latch, so one period is latch+1 ticks. After an underflow, timer 2 stops. Timer 1 also stops unless free-run is selected.
- R6: Bit 6 of offset 11 selects timer 1 free-run. A write with bit 6 set also starts timer 1 and leaves its counter as it is. Reading offset 11 gives 0x40 when free-run is selected and 0x00 otherwise.
- R7: An underflow sets the timer's flag only while that timer's enable bit is 1.
- R8: A read returns its data on `rd_data` in the cycle after `rd_en`, and `rd_data` holds between reads. The offsets read as follows:
  - Offsets 4 and 8 return the counter low byte and clear that timer's flag.
  - Offsets 5 and 9 return the counter high byte.
  - Offsets 6 and 7 return the timer 1 latch bytes.
  - Unmapped offsets return 0x00.
- R9: At offset 13, bit 6 is the timer 1 flag and bit 5 is the timer 2 flag. Bit 7 reads as 1 when either flag is set. Writing 1 to bit 6 or bit 5 clears that flag. Writing 0 has no effect.
- R10: A write to offset 14 copies bit 7 into each enable whose select bit is 1 (bit 6 for timer 1, bit 5 for timer 2). A read of offset 14 returns bit 7 as 1 and the enables in bits 6 and 5.
- R11: `irq` is registered. It rises one cycle after a flag with its enable set appears. It falls one cycle after the last such flag clears or is masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one step per high cycle |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The hardest case to reach is timer 1 being stopped after a one-shot underflow while its latch differs from its counter. Reaching it requires leaving free-run and then counting through a full period. Only then can a latch-high write at offset 7 be shown not to reload or restart the counter, by comparing its counter high byte with the latch. The stimulus reaches this state in a fixed order: free-run is set and then cleared on a running timer, the period is counted out, and the counter and flags are read back. The interrupt timing is checked cycle by cycle around a flag clear and around an enable mask.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 4;
  localparam int NUM_CH = 2;

  localparam logic [ADDR_W-1:0] OFS_T1_CLO = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_T1_CHI = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_T1_LLO = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_T1_LHI = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_T2_LO  = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_T2_HI  = 4'd9;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 4'd11;
  localparam logic [ADDR_W-1:0] OFS_FLAG   = 4'd13;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 4'd14;

  localparam int BIT_FREE   = 6;
  localparam int BIT_SETCLR = 7;
  localparam int BIT_ANY    = 7;

  localparam logic [CNT_W-1:0] T1_RST_LATCH = 16'h1FFF;

  // flag/enable bit position of channel ch in the flag and mask registers
  function automatic int flag_pos(int ch);
    return 6 - ch;
  endfunction
endpackage

// File: rtl/dtim_chan.sv
module dtim_chan
  import dtim_pkg::*;
#(
  parameter int              W         = CNT_W,
  parameter int              BW        = BYTE_W,
  parameter bit              HAS_FREE  = 1'b0,
  parameter logic [W-1:0]    RST_LATCH = '0,
  parameter bit              RST_RUN   = 1'b0,
  parameter bit              RST_FREE  = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_lo,
  input  logic          wr_load,
  input  logic          wr_hi,
  input  logic          mode_we,
  input  logic          mode_free,
  input  logic [BW-1:0] wr_data,
  output logic [W-1:0]  cnt_o,
  output logic [W-1:0]  latch_o,
  output logic          run_o,
  output logic          free_o,
  output logic          uf_o
);
  localparam int HI_W = W - BW;

  logic [W-1:0] cnt_q;
  logic [W-1:0] latch_q;
  logic         run_q;
  logic         free_q;
  logic         uf;
  logic         mode_start;

  assign uf         = run_q && tick && (cnt_q == '0) && !wr_load;
  assign mode_start = HAS_FREE && mode_we && mode_free;

  generate
    if (HAS_FREE) begin : g_free
      always_ff @(posedge clk) begin
        if (rst)          free_q <= RST_FREE;
        else if (mode_we) free_q <= mode_free;
      end
    end else begin : g_oneshot
      assign free_q = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      latch_q <= RST_LATCH;
      run_q   <= RST_RUN;
    end else begin
      if (wr_lo)
        latch_q[BW-1:0] <= wr_data;
      if (wr_load || wr_hi)
        latch_q[W-1:BW] <= wr_data[HI_W-1:0];
      if (wr_load) begin
        cnt_q <= {wr_data[HI_W-1:0], latch_q[BW-1:0]};
        run_q <= 1'b1;
      end else begin
        if (run_q && tick)
          cnt_q <= (cnt_q == '0) ? latch_q : cnt_q - 1'b1;
        if (uf && !free_q)
          run_q <= 1'b0;
        if (mode_start)
          run_q <= 1'b1;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;
  assign run_o   = run_q;
  assign free_o  = free_q;
  assign uf_o    = uf;

  // R5: one step down per tick while running
  a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
    run_q && tick && !wr_load && cnt_q != '0 |=> cnt_q == $past(cnt_q) - W'(1));
  // R5: reload from the latch on underflow
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    run_q && tick && !wr_load && !wr_lo && !wr_hi && cnt_q == '0 |=> cnt_q == $past(latch_q));
  // R5: one-shot stops after underflow
  a_r5_stop: assert property (@(posedge clk) disable iff (rst)
    uf && !free_q && !mode_start |=> !run_q);
  // R3: high write loads and starts
  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    wr_load |=> run_o && cnt_q[BW-1:0] == $past(latch_q[BW-1:0]));
  // R2 / R4: latch-only writes leave the counter alone
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_hi || wr_lo) && !tick && !wr_load |=> $stable(cnt_q));
endmodule

// File: rtl/dtim_intc.sv
module dtim_intc
  import dtim_pkg::*;
#(
  parameter int                NCH    = NUM_CH,
  parameter int                BW     = BYTE_W,
  parameter logic [NCH-1:0]    RST_EN = 2'b10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] uf,
  input  logic [NCH-1:0] clr,
  input  logic           flag_we,
  input  logic           mask_we,
  input  logic [BW-1:0]  wr_data,
  output logic [NCH-1:0] flag_o,
  output logic [NCH-1:0] en_o,
  output logic           irq_o
);
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] clr_all;
  logic           irq_q;
  logic [BW-1:0]  wdat_unused;

  assign wdat_unused = wr_data;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int FP = flag_pos(i);

      assign clr_all[i] = clr[i] || (flag_we && wr_data[FP]);

      always_ff @(posedge clk) begin
        if (rst)                          flag_q[i] <= 1'b0;
        else if (uf[i] && en_q[i])        flag_q[i] <= 1'b1;
        else if (clr_all[i])              flag_q[i] <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (rst)                          en_q[i] <= RST_EN[i];
        else if (mask_we && wr_data[FP])  en_q[i] <= wr_data[BIT_SETCLR];
      end

      // R7: a masked underflow raises no flag
      a_r7_masked: assert property (@(posedge clk) disable iff (rst)
        uf[i] && !en_q[i] && !flag_q[i] |=> !flag_q[i]);
      // R9: a clear without a new event leaves the flag low
      a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr_all[i] && !uf[i] |=> !flag_q[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_q & en_q);
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  // R11: request falls one cycle after no enabled flag remains
  a_r11_drop: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & en_q)) |=> !irq_o);
endmodule

// File: rtl/dtim_regif.sv
module dtim_regif
  import dtim_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int BW  = BYTE_W,
  parameter int W   = CNT_W,
  parameter int NCH = NUM_CH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [W-1:0]   cnt1,
  input  logic [W-1:0]   latch1,
  input  logic           free1,
  input  logic [W-1:0]   cnt2,
  input  logic [NCH-1:0] flags,
  input  logic [NCH-1:0] ens,
  output logic           t1_wr_lo,
  output logic           t1_wr_load,
  output logic           t1_wr_hi,
  output logic           t2_wr_lo,
  output logic           t2_wr_load,
  output logic           mode_we,
  output logic           flag_we,
  output logic           mask_we,
  output logic           rd_clr1,
  output logic           rd_clr2,
  output logic [BW-1:0]  rd_data_o
);
  logic [BW-1:0] rd_mux;
  logic [BW-1:0] flag_byte;
  logic [BW-1:0] mask_byte;
  logic [BW-1:0] rd_q;

  assign t1_wr_lo   = wr_en && (addr == OFS_T1_CLO || addr == OFS_T1_LLO);
  assign t1_wr_load = wr_en && (addr == OFS_T1_CHI);
  assign t1_wr_hi   = wr_en && (addr == OFS_T1_LHI);
  assign t2_wr_lo   = wr_en && (addr == OFS_T2_LO);
  assign t2_wr_load = wr_en && (addr == OFS_T2_HI);
  assign mode_we    = wr_en && (addr == OFS_MODE);
  assign flag_we    = wr_en && (addr == OFS_FLAG);
  assign mask_we    = wr_en && (addr == OFS_MASK);
  assign rd_clr1    = rd_en && (addr == OFS_T1_CLO);
  assign rd_clr2    = rd_en && (addr == OFS_T2_LO);

  always_comb begin
    flag_byte = '0;
    mask_byte = '0;
    for (int i = 0; i < NCH; i++) begin
      flag_byte[flag_pos(i)] = flags[i];
      mask_byte[flag_pos(i)] = ens[i];
    end
    flag_byte[BIT_ANY]    = |flags;
    mask_byte[BIT_SETCLR] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_T1_CLO: rd_mux = cnt1[BW-1:0];
      OFS_T1_CHI: rd_mux = cnt1[W-1:BW];
      OFS_T1_LLO: rd_mux = latch1[BW-1:0];
      OFS_T1_LHI: rd_mux = latch1[W-1:BW];
      OFS_T2_LO:  rd_mux = cnt2[BW-1:0];
      OFS_T2_HI:  rd_mux = cnt2[W-1:BW];
      OFS_MODE:   rd_mux[BIT_FREE] = free1;
      OFS_FLAG:   rd_mux = flag_byte;
      OFS_MASK:   rd_mux = mask_byte;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  // R8: read data holds between reads
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data_o));
  // R8: unmapped offset reads zero
  a_r8_unmapped: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == '0 |=> rd_data_o == '0);
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtim_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W,
  parameter int W  = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_data,
  input  logic          rd_en,
  output logic [BW-1:0] rd_data,
  output logic          irq
);
  localparam int NCH = NUM_CH;

  logic t1_wr_lo, t1_wr_load, t1_wr_hi, t2_wr_lo, t2_wr_load;
  logic mode_we, flag_we, mask_we, rd_clr1, rd_clr2;
  logic [W-1:0] cnt1, latch1, cnt2, t2_latch_unused;
  logic run1, run2, free1, free2_unused;
  logic [NCH-1:0] uf, clr, flags, ens;

  dtim_chan #(
    .W(W), .BW(BW), .HAS_FREE(1'b1),
    .RST_LATCH(T1_RST_LATCH), .RST_RUN(1'b1), .RST_FREE(1'b1)
  ) u_t1 (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_lo(t1_wr_lo), .wr_load(t1_wr_load), .wr_hi(t1_wr_hi),
    .mode_we(mode_we), .mode_free(wr_data[BIT_FREE]), .wr_data(wr_data),
    .cnt_o(cnt1), .latch_o(latch1), .run_o(run1), .free_o(free1), .uf_o(uf[0])
  );

  dtim_chan #(
    .W(W), .BW(BW), .HAS_FREE(1'b0),
    .RST_LATCH('0), .RST_RUN(1'b0), .RST_FREE(1'b0)
  ) u_t2 (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_lo(t2_wr_lo), .wr_load(t2_wr_load), .wr_hi(1'b0),
    .mode_we(1'b0), .mode_free(1'b0), .wr_data(wr_data),
    .cnt_o(cnt2), .latch_o(t2_latch_unused), .run_o(run2), .free_o(free2_unused),
    .uf_o(uf[1])
  );

  assign clr[0] = t1_wr_load || t1_wr_hi || rd_clr1;
  assign clr[1] = t2_wr_load || rd_clr2;

  dtim_intc #(.NCH(NCH), .BW(BW), .RST_EN(2'b10)) u_intc (
    .clk(clk), .rst(rst), .uf(uf), .clr(clr),
    .flag_we(flag_we), .mask_we(mask_we), .wr_data(wr_data),
    .flag_o(flags), .en_o(ens), .irq_o(irq)
  );

  dtim_regif #(.AW(AW), .BW(BW), .W(W), .NCH(NCH)) u_regif (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .cnt1(cnt1), .latch1(latch1), .free1(free1), .cnt2(cnt2),
    .flags(flags), .ens(ens),
    .t1_wr_lo(t1_wr_lo), .t1_wr_load(t1_wr_load), .t1_wr_hi(t1_wr_hi),
    .t2_wr_lo(t2_wr_lo), .t2_wr_load(t2_wr_load),
    .mode_we(mode_we), .flag_we(flag_we), .mask_we(mask_we),
    .rd_clr1(rd_clr1), .rd_clr2(rd_clr2), .rd_data_o(rd_data)
  );

  // R5: a stopped timer 2 holds its counter
  a_r5_t2_idle: assert property (@(posedge clk) disable iff (rst)
    !run2 && !t2_wr_load |=> $stable(cnt2));
  // R1: timer 1 holds its counter when stopped
  a_r1_t1_idle: assert property (@(posedge clk) disable iff (rst)
    !run1 && !t1_wr_load && !(mode_we && wr_data[BIT_FREE]) |=> $stable(cnt1));
endmodule

// File: tb/dual_timer_test.sv
module dual_timer_test;
  localparam int  NV   = 68;
  localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OT = 2'd2;

  // {op, addr, data, expected, requirement number}
  localparam logic [29:0] VEC [NV] = '{
    {OW, 4'd11, 8'h00, 8'h00, 8'd6},   // R6 one-shot
    {OW, 4'd14, 8'hE0, 8'h00, 8'd10},  // R10 enable both
    {ORD,4'd14, 8'h00, 8'hE0, 8'd10},
    {OW, 4'd6,  8'h05, 8'h00, 8'd2},   // R2 latch low
    {OW, 4'd7,  8'h00, 8'h00, 8'd4},   // R4 latch high
    {ORD,4'd5,  8'h00, 8'h00, 8'd4},
    {ORD,4'd4,  8'h00, 8'h00, 8'd2},
    {OT, 4'd0,  8'd1,  8'h00, 8'd5},   // R5 underflow from 0
    {ORD,4'd13, 8'h00, 8'hC0, 8'd7},   // R7 flag with enable
    {ORD,4'd4,  8'h00, 8'h05, 8'd8},   // R8 clears flag
    {ORD,4'd13, 8'h00, 8'h00, 8'd8},
    {OT, 4'd0,  8'd3,  8'h00, 8'd5},
    {ORD,4'd4,  8'h00, 8'h05, 8'd5},   // R5 stopped one-shot
    {OW, 4'd4,  8'h03, 8'h00, 8'd2},
    {ORD,4'd4,  8'h00, 8'h05, 8'd2},   // R2 counter untouched
    {ORD,4'd6,  8'h00, 8'h03, 8'd8},
    {OW, 4'd5,  8'h00, 8'h00, 8'd3},   // R3 load and start
    {OT, 4'd0,  8'd3,  8'h00, 8'd5},
    {ORD,4'd13, 8'h00, 8'h00, 8'd5},
    {ORD,4'd4,  8'h00, 8'h00, 8'd5},
    {OT, 4'd0,  8'd1,  8'h00, 8'd5},
    {ORD,4'd13, 8'h00, 8'hC0, 8'd5},
    {OW, 4'd13, 8'h40, 8'h00, 8'd9},   // R9 write 1 clears
    {ORD,4'd13, 8'h00, 8'h00, 8'd9},
    {OW, 4'd11, 8'h40, 8'h00, 8'd6},   // R6 free-run starts
    {ORD,4'd11, 8'h00, 8'h40, 8'd6},
    {OT, 4'd0,  8'd4,  8'h00, 8'd6},
    {ORD,4'd13, 8'h00, 8'hC0, 8'd6},
    {OW, 4'd13, 8'h40, 8'h00, 8'd9},
    {OT, 4'd0,  8'd4,  8'h00, 8'd6},
    {ORD,4'd4,  8'h00, 8'h03, 8'd8},
    {ORD,4'd13, 8'h00, 8'h00, 8'd8},
    {OW, 4'd11, 8'h00, 8'h00, 8'd6},
    {ORD,4'd11, 8'h00, 8'h00, 8'd6},
    {OT, 4'd0,  8'd4,  8'h00, 8'd5},
    {ORD,4'd13, 8'h00, 8'hC0, 8'd5},
    {OW, 4'd13, 8'h40, 8'h00, 8'd9},
    {OT, 4'd0,  8'd5,  8'h00, 8'd5},
    {ORD,4'd4,  8'h00, 8'h03, 8'd5},   // R5 timer 1 stopped
    {OW, 4'd8,  8'h02, 8'h00, 8'd2},
    {OW, 4'd9,  8'h00, 8'h00, 8'd3},
    {OT, 4'd0,  8'd2,  8'h00, 8'd5},
    {ORD,4'd8,  8'h00, 8'h00, 8'd5},
    {OT, 4'd0,  8'd1,  8'h00, 8'd5},
    {ORD,4'd13, 8'h00, 8'hA0, 8'd9},
    {OT, 4'd0,  8'd3,  8'h00, 8'd5},
    {ORD,4'd8,  8'h00, 8'h02, 8'd8},   // R5 timer 2 stopped
    {ORD,4'd13, 8'h00, 8'h00, 8'd8},
    {OW, 4'd14, 8'h20, 8'h00, 8'd10},  // R10 clear enable
    {ORD,4'd14, 8'h00, 8'hC0, 8'd10},
    {OW, 4'd9,  8'h00, 8'h00, 8'd3},
    {OT, 4'd0,  8'd3,  8'h00, 8'd7},
    {ORD,4'd13, 8'h00, 8'h00, 8'd7},   // R7 masked
    {ORD,4'd8,  8'h00, 8'h02, 8'd5},
    {OW, 4'd14, 8'hA0, 8'h00, 8'd10},
    {ORD,4'd14, 8'h00, 8'hE0, 8'd10},
    {OW, 4'd7,  8'h12, 8'h00, 8'd4},
    {ORD,4'd5,  8'h00, 8'h00, 8'd4},   // R4 no reload
    {ORD,4'd7,  8'h00, 8'h12, 8'd8},
    {ORD,4'd9,  8'h00, 8'h00, 8'd8},
    {ORD,4'd0,  8'h00, 8'h00, 8'd8},
    {ORD,4'd10, 8'h00, 8'h00, 8'd8},
    {OW, 4'd6,  8'h00, 8'h00, 8'd2},
    {OW, 4'd5,  8'h00, 8'h00, 8'd3},
    {OT, 4'd0,  8'd1,  8'h00, 8'd5},
    {ORD,4'd13, 8'h00, 8'hC0, 8'd5},
    {OW, 4'd7,  8'h00, 8'h00, 8'd4},   // R4 clears flag
    {ORD,4'd13, 8'h00, 8'h00, 8'd4}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  dual_timer uut (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    do_read(4'd11, v); check("R1 mode", v, 8'h40);
    do_read(4'd14, v); check("R1 mask", v, 8'hA0);
    do_read(4'd13, v); check("R1 flags", v, 8'h00);
    do_read(4'd6,  v); check("R1 latch lo", v, 8'hFF);
    do_read(4'd7,  v); check("R1 latch hi", v, 8'h1F);
    do_read(4'd5,  v); check("R1 cnt hi", v, 8'h00);
    do_read(4'd9,  v); check("R1 t2 cnt hi", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] a;
      logic [7:0] d, e, rq;
      {op, a, d, e, rq} = VEC[i];
      case (op)
        OW:  do_write(a, d);
        OT:  do_ticks(int'(d));
        default: begin
          do_read(a, v);
          check($sformatf("R%0d vec %0d", rq, i), v, e);
        end
      endcase
    end

    // R11 registered request and its fall after a clear
    check("R11 idle", {7'd0, irq}, 8'h00);
    do_write(4'd8, 8'h01);
    do_write(4'd9, 8'h00);
    do_ticks(2);
    check("R11 one cycle late", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R11 asserted", {7'd0, irq}, 8'h01);
    do_write(4'd13, 8'h20);
    check("R11 held one cycle", {7'd0, irq}, 8'h01);
    @(negedge clk);
    check("R11 deasserted", {7'd0, irq}, 8'h00);

    // R11 masking drops the request, R10 flag stays visible
    do_write(4'd9, 8'h00);
    do_ticks(2);
    @(negedge clk);
    check("R11 asserted again", {7'd0, irq}, 8'h01);
    do_write(4'd14, 8'h20);
    @(negedge clk);
    check("R11 masked", {7'd0, irq}, 8'h00);
    do_read(4'd13, v); check("R10 flag kept", v, 8'hA0);
    @(negedge clk);
    check("R8 read hold", v, rd_data);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule